// File: doc/BRIEF.md
# Triple-Lane Redundancy Fault Manager

This block sits behind three identical copies of a streaming processing chain and merges their outputs into one protected stream. On every accepted beat it forms a bitwise two-of-three vote across the lanes. It also manages the health of the lanes.

A programmable timer takes one lane at a time out of the vote for a self-test. An outside test engine reports, for each lane, a done pulse and a pass level. A lane that fails is excluded for good, and the vote then falls back to the lanes that remain. A lane that keeps losing the three-way vote is sent to test ahead of schedule.

A second, independent timer raises a configuration-scrub request. The request follows a request/acknowledge handshake.

The stream uses valid/ready on both sides with no storage in between. The three lanes share one `in_valid_i`. `out_valid_o` follows `in_valid_i` whenever at least one lane is in the vote. Back-pressure is passed straight through: `in_ready_o` equals `out_ready_i`, except when no lane is in the vote. In that case beats are accepted and dropped, with `in_ready_o` high and `out_valid_o` low. A beat counts as accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high.

Top module: `tmr_fault_mgr`

## Requirements
- R1: With all three lanes in the vote, `out_data_o` is the bitwise majority of the three lane words, and `miscompare_o` is 0.
- R2: With exactly two lanes in the vote, `out_data_o` is the lower-indexed lane's word. `miscompare_o` is 1 during a valid beat in which the two words differ, and 0 when they are equal.
- R3: With one lane in the vote, its word passes through unchanged. `degraded_o` is 1 when exactly one lane is healthy. When no lane is in the vote, `out_valid_o` is 0. `fatal_o` is 1 when no lane is healthy.
- R4: `out_valid_o` = `in_valid_i` while any lane is in the vote. `in_ready_o` = `out_ready_i`, or 1 when no lane is in the vote.
- R5: A nonzero `test_interval_i` of N starts a test on the Nth clock edge of idle time, counted from reset or from the end of the previous test. A value of 0 stops scheduled tests. The timer does not run while a test is in progress.
- R6: Scheduled tests go round-robin in the order lane 0, 1, 2, starting after the last lane tested and skipping excluded lanes. The lane under test is left out of the vote.
- R7: A test ends on the edge where `test_done_i[lane]` is high. If `test_pass_i[lane]` is 0 at that edge, the lane's bit in `healthy_o` clears and never sets again until reset. A passing lane stays healthy.
- R8: Each lane has a saturating counter of accepted beats in which it disagrees with the three-lane vote. When a counter reaches a nonzero `disagree_thresh_i`, that lane is tested on the next idle edge, ahead of the timer. The counter clears when the lane's test ends.
- R9: A nonzero `scrub_interval_i` of N raises `scrub_req_o` on the Nth edge after reset or after the previous acknowledge. The request stays high until an edge with `scrub_ack_i` high. The interval does not run while a request is outstanding.
- R10: `sticky_o` bit 0 records a two-lane miscompare on an accepted beat, bit 1 records a lane exclusion, and bit 2 records the fatal state. A 1 written on `sticky_clr_i` clears that bit at the next edge, unless its event recurs in the same cycle, in which case setting wins.
- R11: `healthy_o` is a lane mask with bit i for lane i. `test_active_o` is high during a test, and `test_lane_o` gives the index of the lane under test, stable for the whole test. Reset gives `healthy_o`=3'b111, no test, no scrub request and `sticky_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_data_i | input | 3*W | Lane words; lane i at bits [i*W +: W] |
| in_valid_i | input | 1 | Shared valid of the three lanes |
| in_ready_o | output | 1 | Ready back to the lanes |
| out_data_o | output | W | Voted word |
| out_valid_o | output | 1 | Voted word valid |
| out_ready_i | input | 1 | Downstream ready |
| test_interval_i | input | CW | Idle cycles between scheduled tests; 0 disables |
| disagree_thresh_i | input | DW | Loss count that forces a test; 0 disables |
| test_done_i | input | 3 | Test finished, one bit per lane |
| test_pass_i | input | 3 | Test result, one bit per lane |
| scrub_interval_i | input | CW | Cycles between scrub requests; 0 disables |
| scrub_ack_i | input | 1 | Scrub acknowledge |
| scrub_req_o | output | 1 | Scrub request |
| healthy_o | output | 3 | Healthy-lane mask |
| test_active_o | output | 1 | Test in progress |
| test_lane_o | output | 2 | Lane under test |
| miscompare_o | output | 1 | Two-lane disagreement on a valid beat |
| degraded_o | output | 1 | Exactly one healthy lane |
| fatal_o | output | 1 | No healthy lane |
| sticky_o | output | 3 | Sticky flags: miscompare, exclusion, fatal |
| sticky_clr_i | input | 3 | Write-one-to-clear for sticky_o |

## Verification
The three-way vote is checked against word triples of several kinds, which separate a true per-bit majority from the simpler policies of "pick a lane" or "pick the odd one out":
- all three equal;
- one lane differing;
- each lane the minority in different bit positions;
- no two lanes sharing any set bit.

The two-lane vote is checked with agreeing and disagreeing pairs, both while a lane is under test and after a lane has been excluded. This shows that the lowest-index choice and the miscompare flag depend on the set of lanes in the vote, not on any fixed lane.

A sequence of passing and failing tests walks the healthy set down from three lanes to none, checking the round-robin order with a skipped lane, the degraded and fatal states, and the sticky flags. The forced test is checked just below and exactly at its threshold. The scrub handshake is checked for its interval, for holding the request without an acknowledge, and for a clean restart after one.

// File: rtl/tmr_fmu_pkg.sv
package tmr_fmu_pkg;
  localparam int NLANE = 3;
  typedef logic [NLANE-1:0] lane_mask_t;
  typedef logic [1:0]       lane_idx_t;
  localparam int STK_MIS  = 0;
  localparam int STK_EXCL = 1;
  localparam int STK_DEAD = 2;
  localparam int NSTK     = 3;

  function automatic lane_idx_t next_lane(input lane_idx_t l);
    return (l == lane_idx_t'(NLANE - 1)) ? lane_idx_t'(0) : lane_idx_t'(l + 1'b1);
  endfunction
endpackage

// File: rtl/tmr_fmu_voter.sv
module tmr_fmu_voter
  import tmr_fmu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [NLANE*W-1:0] lanes_i,
  input  lane_mask_t         act_i,
  output logic [W-1:0]       data_o,
  output logic               mis_o,
  output logic               none_o,
  output lane_mask_t         lose_o
);
  logic [W-1:0] word [NLANE];
  logic [1:0]   n_act;
  lane_idx_t    lo_idx, hi_idx;

  for (genvar g = 0; g < NLANE; g++) begin : g_split
    assign word[g] = lanes_i[g*W +: W];
  end

  assign n_act = 2'($countones(act_i));

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = NLANE - 1; i >= 0; i--) if (act_i[i]) lo_idx = lane_idx_t'(i);
    for (int i = 0; i < NLANE; i++)      if (act_i[i]) hi_idx = lane_idx_t'(i);
  end

  always_comb begin
    data_o = '0;
    mis_o  = 1'b0;
    none_o = 1'b0;
    case (n_act)
      2'd3: data_o = (word[0] & word[1]) | (word[0] & word[2]) | (word[1] & word[2]);
      2'd2: begin
        data_o = word[lo_idx];
        mis_o  = (word[lo_idx] != word[hi_idx]);
      end
      2'd1: data_o = word[lo_idx];
      default: none_o = 1'b1;
    endcase
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lose
    assign lose_o[g] = (n_act == 2'd3) && (word[g] != data_o);
  end
endmodule

// File: rtl/tmr_fmu_test_ctrl.sv
module tmr_fmu_test_ctrl
  import tmr_fmu_pkg::*;
#(
  parameter int CW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] interval_i,
  input  logic [DW-1:0] thresh_i,
  input  logic          beat_i,
  input  lane_mask_t    lose_i,
  input  lane_mask_t    done_i,
  input  lane_mask_t    pass_i,
  output lane_mask_t    healthy_o,
  output logic          active_o,
  output lane_idx_t     lane_o,
  output logic          excl_o
);
  localparam logic [DW-1:0] DMAX = '1;

  lane_mask_t    healthy;
  logic          active;
  lane_idx_t     lane, rr;
  logic [CW-1:0] tcnt;
  logic [DW-1:0] dcnt [NLANE];
  logic          force_any, timer_hit, finish;
  lane_idx_t     force_lane, sched_lane;

  always_comb begin
    force_any  = 1'b0;
    force_lane = '0;
    for (int i = NLANE - 1; i >= 0; i--) begin
      if (healthy[i] && thresh_i != '0 && dcnt[i] >= thresh_i) begin
        force_any  = 1'b1;
        force_lane = lane_idx_t'(i);
      end
    end
  end

  always_comb begin
    sched_lane = rr;
    for (int k = NLANE - 1; k >= 0; k--) begin
      logic [2:0] s;
      s = 3'(rr) + 3'(k);
      if (s >= 3'(NLANE)) s = s - 3'(NLANE);
      if (healthy[s[1:0]]) sched_lane = s[1:0];
    end
  end

  assign timer_hit = (interval_i != '0) && (tcnt >= interval_i - CW'(1));
  assign finish    = active && done_i[lane];
  assign excl_o    = finish && !pass_i[lane];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      healthy <= '1;
      active  <= 1'b0;
      lane    <= '0;
      rr      <= '0;
      tcnt    <= '0;
    end else if (!active) begin
      if (force_any) begin
        active <= 1'b1;
        lane   <= force_lane;
        tcnt   <= '0;
      end else if (healthy != '0 && timer_hit) begin
        active <= 1'b1;
        lane   <= sched_lane;
        tcnt   <= '0;
      end else if (healthy != '0 && interval_i != '0) begin
        tcnt <= tcnt + CW'(1);
      end
    end else if (finish) begin
      active <= 1'b0;
      rr     <= next_lane(lane);
      if (!pass_i[lane]) healthy[lane] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_dcnt
    always_ff @(posedge clk) begin
      if (!rst_n) dcnt[g] <= '0;
      else if (finish && lane == lane_idx_t'(g)) dcnt[g] <= '0;
      else if (beat_i && lose_i[g] && dcnt[g] != DMAX) dcnt[g] <= dcnt[g] + DW'(1);
    end
  end

  assign healthy_o = healthy;
  assign active_o  = active;
  assign lane_o    = lane;

  p_excluded_stays_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((healthy & ~$past(healthy)) == '0));
  p_test_on_healthy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> healthy[lane]);
  p_lane_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done_i[lane]) |=> (active && $stable(lane)));
endmodule

// File: rtl/tmr_fmu_scrub.sv
module tmr_fmu_scrub #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] interval_i,
  input  logic          ack_i,
  output logic          req_o
);
  logic [CW-1:0] cnt;
  logic          req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= 1'b0;
      cnt <= '0;
    end else if (req) begin
      if (ack_i) req <= 1'b0;
    end else if (interval_i != '0) begin
      if (cnt >= interval_i - CW'(1)) begin
        req <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign req_o = req;

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack_i) |=> req);
  p_req_drops_on_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack_i) |=> !req);
endmodule

// File: rtl/tmr_fault_mgr.sv
module tmr_fault_mgr
  import tmr_fmu_pkg::*;
#(
  parameter int W  = 16,
  parameter int CW = 24,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3*W-1:0]  lane_data_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic [W-1:0]    out_data_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  input  logic [CW-1:0]   test_interval_i,
  input  logic [DW-1:0]   disagree_thresh_i,
  input  logic [2:0]      test_done_i,
  input  logic [2:0]      test_pass_i,
  input  logic [CW-1:0]   scrub_interval_i,
  input  logic            scrub_ack_i,
  output logic            scrub_req_o,
  output logic [2:0]      healthy_o,
  output logic            test_active_o,
  output logic [1:0]      test_lane_o,
  output logic            miscompare_o,
  output logic            degraded_o,
  output logic            fatal_o,
  output logic [2:0]      sticky_o,
  input  logic [2:0]      sticky_clr_i
);
  lane_mask_t healthy, act, lose;
  logic       active, none, mis, beat, excl;
  lane_idx_t  lane;
  logic [1:0] n_ok;
  logic [NSTK-1:0] sticky, stk_set;

  assign act = healthy & ~(active ? lane_mask_t'(3'b001 << lane) : lane_mask_t'(0));

  tmr_fmu_voter #(.W(W)) u_voter (
    .lanes_i (lane_data_i),
    .act_i   (act),
    .data_o  (out_data_o),
    .mis_o   (mis),
    .none_o  (none),
    .lose_o  (lose)
  );

  assign out_valid_o  = in_valid_i && !none;
  assign in_ready_o   = out_ready_i || none;
  assign beat         = in_valid_i && in_ready_o && !none;
  assign miscompare_o = in_valid_i && mis;

  tmr_fmu_test_ctrl #(.CW(CW), .DW(DW)) u_test (
    .clk        (clk),
    .rst_n      (rst_n),
    .interval_i (test_interval_i),
    .thresh_i   (disagree_thresh_i),
    .beat_i     (beat),
    .lose_i     (lose),
    .done_i     (test_done_i),
    .pass_i     (test_pass_i),
    .healthy_o  (healthy),
    .active_o   (active),
    .lane_o     (lane),
    .excl_o     (excl)
  );

  tmr_fmu_scrub #(.CW(CW)) u_scrub (
    .clk        (clk),
    .rst_n      (rst_n),
    .interval_i (scrub_interval_i),
    .ack_i      (scrub_ack_i),
    .req_o      (scrub_req_o)
  );

  assign n_ok       = 2'($countones(healthy));
  assign degraded_o = (n_ok == 2'd1);
  assign fatal_o    = (n_ok == 2'd0);

  always_comb begin
    stk_set           = '0;
    stk_set[STK_MIS]  = beat && mis;
    stk_set[STK_EXCL] = excl;
    stk_set[STK_DEAD] = fatal_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~sticky_clr_i) | stk_set;
  end

  assign sticky_o      = sticky;
  assign healthy_o     = healthy;
  assign test_active_o = active;
  assign test_lane_o   = lane;

  p_fatal_blocks_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> !out_valid_o);
  p_stall_passes_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  p_excl_sets_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    excl |=> sticky_o[STK_EXCL]);
endmodule

// File: tb/tmr_fault_mgr_bench.sv
`timescale 1ns/1ps
module tmr_fault_mgr_bench;
  localparam int W = 8, CW = 16, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3*W-1:0] lane_data = '0;
  logic in_valid = 0, out_ready = 1, scrub_ack = 0;
  logic [CW-1:0] t_int = '0, s_int = '0;
  logic [DW-1:0] thresh = '0;
  logic [2:0] t_done = '0, t_pass = '0, stk_clr = '0;
  logic in_ready, out_valid, scrub_req, t_act, mis, degr, fatal;
  logic [W-1:0] out_data;
  logic [2:0] healthy, sticky;
  logic [1:0] t_lane;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmr_fault_mgr #(.W(W), .CW(CW), .DW(DW)) u_tmr_fault_mgr (
    .clk(clk), .rst_n(rst_n), .lane_data_i(lane_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .out_data_o(out_data), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .test_interval_i(t_int), .disagree_thresh_i(thresh),
    .test_done_i(t_done), .test_pass_i(t_pass), .scrub_interval_i(s_int),
    .scrub_ack_i(scrub_ack), .scrub_req_o(scrub_req), .healthy_o(healthy),
    .test_active_o(t_act), .test_lane_o(t_lane), .miscompare_o(mis),
    .degraded_o(degr), .fatal_o(fatal), .sticky_o(sticky), .sticky_clr_i(stk_clr)
  );

  // {lane0, lane1, lane2, expected majority}
  localparam logic [31:0] VEC [8] = '{
    32'hAAAAAAAA, 32'hAA55AAAA, 32'h0F335517, 32'hFF000000,
    32'h3C3CC33C, 32'h12343434, 32'hF00FFFFF, 32'h81422400 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic v);
    lane_data = {c, b, a};
    in_valid  = v;
  endtask

  task automatic wait_test(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!t_act && n < 200);
  endtask

  task automatic end_test(input int l, input logic ok);
    t_done[l] = 1'b1; t_pass[l] = ok;
    @(negedge clk);
    t_done = '0; t_pass = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; drive(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    #1;
    chk("R11 reset healthy", 32'(healthy), 32'h7);
    chk("R11 reset test", 32'(t_act), 0);
    chk("R11 reset scrub", 32'(scrub_req), 0);
    chk("R11 reset sticky", 32'(sticky), 0);
    chk("R4 no valid idle", 32'(out_valid), 0);

    // R1: three-lane vote table
    foreach (VEC[i]) begin
      @(negedge clk);
      drive(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], 1'b1);
      #1;
      chk($sformatf("R1 vote vec%0d", i), 32'(out_data), 32'(VEC[i][7:0]));
      chk("R1 no miscompare", 32'(mis), 0);
    end
    // R4 back-pressure
    out_ready = 0; #1;
    chk("R4 stall ready", 32'(in_ready), 0);
    chk("R4 stall valid", 32'(out_valid), 1);
    @(negedge clk); out_ready = 1; in_valid = 0; #1;
    chk("R4 valid follows input", 32'(out_valid), 0);
    chk("R10 no sticky yet", 32'(sticky), 0);

    // R5 scheduled test
    t_int = 5;
    wait_test(n);
    chk("R5 interval edges", n, 5);
    chk("R6 first lane", 32'(t_lane), 0);
    drive(8'hFF, 8'h11, 8'h11, 1); #1;
    chk("R2 pair agree", 32'(out_data), 32'h11);
    chk("R2 pair agree flag", 32'(mis), 0);
    @(negedge clk); drive(8'hFF, 8'h11, 8'h22, 1); #1;
    chk("R2 pair differ low lane", 32'(out_data), 32'h11);
    chk("R2 pair differ flag", 32'(mis), 1);
    @(negedge clk); in_valid = 0;
    chk("R10 miscompare sticky", 32'(sticky), 3'b001);
    end_test(0, 1);
    chk("R7 pass keeps lane", 32'(healthy), 3'b111);
    wait_test(n);
    chk("R6 rr lane1", 32'(t_lane), 1);
    end_test(1, 0);
    chk("R7 fail excludes", 32'(healthy), 3'b101);
    chk("R10 exclusion sticky", 32'(sticky[1]), 1);
    wait_test(n); chk("R6 rr lane2", 32'(t_lane), 2); end_test(2, 1);
    wait_test(n); chk("R6 rr wrap lane0", 32'(t_lane), 0); end_test(0, 1);
    wait_test(n); chk("R6 skip excluded", 32'(t_lane), 2);
    drive(8'h66, 8'h99, 8'h33, 1); #1;
    chk("R3 single active passthrough", 32'(out_data), 32'h66);
    chk("R3 not degraded two healthy", 32'(degr), 0);
    @(negedge clk); in_valid = 0; t_int = 0;
    end_test(2, 1);
    drive(8'h10, 8'h00, 8'h20, 1); #1;
    chk("R2 excluded pair differ", 32'(out_data), 32'h10);
    chk("R2 excluded pair flag", 32'(mis), 1);
    @(negedge clk); drive(8'h77, 8'h00, 8'h77, 1); #1;
    chk("R7 excluded lane ignored", 32'(out_data), 32'h77);
    chk("R7 excluded lane no flag", 32'(mis), 0);
    @(negedge clk); in_valid = 0; t_int = 5;
    wait_test(n); chk("R6 after lane2", 32'(t_lane), 0);
    end_test(0, 0);
    chk("R7 second exclusion", 32'(healthy), 3'b100);
    drive(8'h01, 8'h02, 8'h5A, 1); #1;
    chk("R3 degraded flag", 32'(degr), 1);
    chk("R3 passthrough", 32'(out_data), 32'h5A);
    @(negedge clk); in_valid = 0;
    wait_test(n); chk("R6 last lane", 32'(t_lane), 2);
    in_valid = 1; #1;
    chk("R3 no lane in vote valid", 32'(out_valid), 0);
    chk("R4 drop ready", 32'(in_ready), 1);
    @(negedge clk); in_valid = 0;
    end_test(2, 0);
    chk("R3 fatal", 32'(fatal), 1);
    @(negedge clk);
    chk("R10 fatal sticky", 32'(sticky), 3'b111);
    stk_clr = 3'b011; @(negedge clk); stk_clr = 0;
    chk("R10 w1c", 32'(sticky), 3'b100);

    // R8 forced test
    t_int = 0; thresh = 3;
    do_reset();
    repeat (2) begin @(negedge clk); drive(8'h05, 8'h05, 8'h09, 1); end
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    chk("R8 below threshold", 32'(t_act), 0);
    drive(8'h05, 8'h05, 8'h09, 1);
    @(negedge clk); in_valid = 0;
    chk("R8 not yet", 32'(t_act), 0);
    @(negedge clk);
    chk("R8 forced start", 32'(t_act), 1);
    chk("R8 forced lane", 32'(t_lane), 2);
    end_test(2, 1);
    repeat (3) @(negedge clk);
    chk("R8 counter cleared", 32'(t_act), 0);

    // R9 scrub
    s_int = 4; n = 0;
    do begin @(negedge clk); n++; end while (!scrub_req && n < 100);
    chk("R9 scrub interval", n, 4);
    repeat (10) @(negedge clk);
    chk("R9 held until ack", 32'(scrub_req), 1);
    scrub_ack = 1; @(negedge clk); scrub_ack = 0;
    chk("R9 drop on ack", 32'(scrub_req), 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!scrub_req && n < 100);
    chk("R9 rearm interval", n, 4);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule